// File: doc/BRIEF.md
# Two-Wide Register Rename Stage with Free List and Branch Checkpoints

This block is the rename stage in front of a unified physical register file. In each cycle it accepts a group of up to two instructions in program order. Each instruction has two architectural source operands and, optionally, one architectural destination. The stage translates every source into the physical register that holds the newest value of that architectural register. Every writing instruction gets a fresh physical register from a circular free list. The stage also reports the physical register that the destination was mapped to before, so that this register can be released when the instruction retires.

The two lanes behave as if they were renamed one after the other. A lane-1 source that names the lane-0 destination receives the register just allocated to lane 0. When both lanes write the same architectural register, lane 1 wins the map entry.

A group can be marked as ending in a predicted branch. In that case the map table, as it stands after the group, is saved into a checkpoint slot together with the free-list read pointer. A misprediction names a slot and restores both in a single cycle. The restore also hands back every register that the wrong path allocated. Correctly resolved branches release the oldest slot.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list hands out the registers ARCH_REGS to PHYS_REGS-1 in ascending order, and in_ready is high.
- R2: Each source of a valid lane comes out as the physical register most recently mapped to that architectural register. This includes writes from earlier groups and excludes any write that was undone by a restore.
- R3: A group that is accepted (in_valid and in_ready) gives each writing lane a distinct register, taken in lane order from the head of the free list. A lane that does not write consumes no register.
- R4: For each writing lane, out_prev carries the physical register that the destination was mapped to just before that lane.
- R5: A lane-1 source equal to the lane-0 destination, when lane 0 writes, gets lane 0's new register in the same cycle.
- R6: When both lanes write the same architectural register, lane 1's out_prev is lane 0's new register, and afterwards the map holds lane 1's register.
- R7: in_ready is low while fewer free registers remain than the group has writing lanes. A group that is not accepted changes neither the map nor the free list.
- R8: A register returned through the commit port joins the tail of the free list. It is handed out only after every register that was already free.
- R9: An accepted branch group saves the map after the group, and the free-list head, into the slot shown on out_snap_id. A misprediction that names that slot restores both on the next edge, holds in_ready low during that cycle, and makes the next allocations repeat the registers that the wrong path received.
- R10: At most SNAPS checkpoints are outstanding. With all slots in use, a branch group stalls while a non-branch group still passes. A correct resolution frees the oldest slot. Slot numbers are assigned cyclically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Group offered |
| in_ready | output | 1 | Group can be accepted this cycle |
| lane_vld | input | 2 | Lane holds an instruction (bit 0 is the older lane) |
| lane_wr | input | 2 | Lane writes a destination |
| lane_src_a | input | 2*AW | First architectural source, lane l in bits [l*AW +: AW] |
| lane_src_b | input | 2*AW | Second architectural source |
| lane_dst | input | 2*AW | Architectural destination |
| grp_branch | input | 1 | Group ends in a predicted branch; take a checkpoint |
| out_src_a | output | 2*PW | Renamed first source, lane l in bits [l*PW +: PW] |
| out_src_b | output | 2*PW | Renamed second source |
| out_dst | output | 2*PW | Newly allocated register (zero for non-writing lanes) |
| out_prev | output | 2*PW | Previous mapping of the destination (zero for non-writing lanes) |
| out_snap_id | output | SW | Checkpoint slot used by a branch group |
| cmt_free_en | input | 1 | Return a register to the free list |
| cmt_free_reg | input | PW | Register being returned |
| br_ok | input | 1 | Oldest outstanding branch resolved correctly |
| br_bad | input | 1 | Branch mispredicted; restore the named checkpoint |
| br_bad_id | input | SW | Checkpoint slot to restore |

## Verification
The bench builds the block with 4 architectural registers, 8 physical registers and 2 checkpoint slots. With these values the free list empties after two groups and the stall of R7 is reached quickly. The FIFO pointers wrap many times during the mixed sequence. Both checkpoint slots fill after two branches, which brings the stall of R10 and the cyclic reuse of slot numbers within a few cycles.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int LANES = 2;

  typedef logic [LANES-1:0] lane_mask_t;

  // Number of lanes set in a mask.
  function automatic logic [1:0] lane_count(input lane_mask_t m);
    return {1'b0, m[0]} + {1'b0, m[1]};
  endfunction
endpackage

// File: rtl/rename_freelist.sv
// Circular queue of free physical registers. The read pointer can be rewound.
module rename_freelist
  import rename_pkg::*;
#(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 48,
  parameter int PW        = 6,
  parameter int HW        = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  lane_mask_t          take,
  output logic [2*PW-1:0]     take_reg,
  output logic [HW-1:0]       avail,
  output logic [HW-1:0]       head_after,
  input  logic                give_en,
  input  logic [PW-1:0]       give_reg,
  input  logic                rewind_en,
  input  logic [HW-1:0]       rewind_head
);
  localparam int NFREE = PHYS_REGS - ARCH_REGS;
  localparam int DW    = HW - 1;
  localparam int DEPTH = 1 << DW;

  logic [PW-1:0] slots_q [DEPTH];
  logic [HW-1:0] head_q, head_d, tail_q, tail_d, head_p1;

  assign head_p1 = head_q + HW'(1);

  assign take_reg[PW-1:0]    = slots_q[head_q[DW-1:0]];
  assign take_reg[2*PW-1:PW] = take[0] ? slots_q[head_p1[DW-1:0]]
                                       : slots_q[head_q[DW-1:0]];

  assign avail      = tail_q - head_q;
  assign head_after = head_q + HW'(lane_count(take));

  always_comb begin
    head_d = rewind_en ? rewind_head : head_after;
    tail_d = give_en ? tail_q + HW'(1) : tail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= HW'(NFREE);
      for (int j = 0; j < DEPTH; j++) begin
        slots_q[j] <= (j < NFREE) ? PW'(ARCH_REGS + j) : '0;
      end
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      if (give_en) begin
        slots_q[tail_q[DW-1:0]] <= give_reg;
      end
    end
  end
endmodule

// File: rtl/rename_map.sv
// Map table: six combinational read ports, two ordered write ports, whole-table load.
module rename_map
  import rename_pkg::*;
#(
  parameter int ARCH_REGS = 16,
  parameter int AW        = 4,
  parameter int PW        = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [6*AW-1:0]         rd_arch,
  output logic [6*PW-1:0]         rd_phys,
  input  lane_mask_t              wr_en,
  input  logic [2*AW-1:0]         wr_arch,
  input  logic [2*PW-1:0]         wr_phys,
  input  logic                    load_en,
  input  logic [ARCH_REGS*PW-1:0] load_map,
  output logic [ARCH_REGS*PW-1:0] map_after
);
  logic [PW-1:0] map_q [ARCH_REGS];
  logic [PW-1:0] map_d [ARCH_REGS];

  for (genvar g = 0; g < 6; g++) begin : g_rd
    assign rd_phys[g*PW +: PW] = map_q[rd_arch[g*AW +: AW]];
  end

  always_comb begin
    for (int i = 0; i < ARCH_REGS; i++) map_d[i] = map_q[i];
    if (load_en) begin
      for (int i = 0; i < ARCH_REGS; i++) map_d[i] = load_map[i*PW +: PW];
    end else begin
      // Lane 1 is applied last, so it wins on an equal destination.
      for (int l = 0; l < LANES; l++) begin
        if (wr_en[l]) map_d[wr_arch[l*AW +: AW]] = wr_phys[l*PW +: PW];
      end
    end
  end

  for (genvar i = 0; i < ARCH_REGS; i++) begin : g_flat
    assign map_after[i*PW +: PW] = map_d[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PW'(i);
    end else begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= map_d[i];
    end
  end
endmodule

// File: rtl/rename_ckpt.sv
// Checkpoint slots, allocated as a circular queue (oldest .. newest).
module rename_ckpt #(
  parameter int NSNAP     = 4,
  parameter int SW        = 2,
  parameter int ARCH_REGS = 16,
  parameter int PW        = 6,
  parameter int HW        = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    save_en,
  input  logic [ARCH_REGS*PW-1:0] save_map,
  input  logic [HW-1:0]           save_head,
  output logic [SW-1:0]           save_id,
  output logic                    full,
  input  logic                    release_en,
  input  logic                    recall_en,
  input  logic [SW-1:0]           recall_id,
  output logic [ARCH_REGS*PW-1:0] recall_map,
  output logic [HW-1:0]           recall_head
);
  logic [ARCH_REGS*PW-1:0] map_st  [NSNAP];
  logic [HW-1:0]           head_st [NSNAP];
  logic [SW:0]             old_q, old_d, new_q, new_d;
  logic [SW-1:0]           keep;

  assign save_id     = new_q[SW-1:0];
  assign full        = (new_q - old_q) == (SW+1)'(NSNAP);
  assign recall_map  = map_st[recall_id];
  assign recall_head = head_st[recall_id];
  // Slots older than the recalled one stay; the recalled slot and younger go.
  assign keep        = recall_id - old_q[SW-1:0];

  always_comb begin
    old_d = release_en ? old_q + (SW+1)'(1) : old_q;
    if (recall_en)    new_d = old_q + {1'b0, keep};
    else if (save_en) new_d = new_q + (SW+1)'(1);
    else              new_d = new_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q <= '0;
      new_q <= '0;
      for (int s = 0; s < NSNAP; s++) begin
        map_st[s]  <= '0;
        head_st[s] <= '0;
      end
    end else begin
      old_q <= old_d;
      new_q <= new_d;
      if (save_en) begin
        map_st[new_q[SW-1:0]]  <= save_map;
        head_st[new_q[SW-1:0]] <= save_head;
      end
    end
  end
endmodule

// File: rtl/reg_rename.sv
module reg_rename
  import rename_pkg::*;
#(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 48,
  parameter int SNAPS     = 4,
  localparam int AW    = $clog2(ARCH_REGS),
  localparam int PW    = $clog2(PHYS_REGS),
  localparam int SW    = $clog2(SNAPS),
  localparam int NFREE = PHYS_REGS - ARCH_REGS,
  localparam int HW    = $clog2(NFREE) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      lane_vld,
  input  logic [1:0]      lane_wr,
  input  logic [2*AW-1:0] lane_src_a,
  input  logic [2*AW-1:0] lane_src_b,
  input  logic [2*AW-1:0] lane_dst,
  input  logic            grp_branch,
  output logic [2*PW-1:0] out_src_a,
  output logic [2*PW-1:0] out_src_b,
  output logic [2*PW-1:0] out_dst,
  output logic [2*PW-1:0] out_prev,
  output logic [SW-1:0]   out_snap_id,
  input  logic            cmt_free_en,
  input  logic [PW-1:0]   cmt_free_reg,
  input  logic            br_ok,
  input  logic            br_bad,
  input  logic [SW-1:0]   br_bad_id
);
  lane_mask_t              wmask, take;
  logic [1:0]              need;
  logic                    fire, snap_full;
  logic [HW-1:0]           avail, head_after, recall_head;
  logic [2*PW-1:0]         new_reg;
  logic [6*AW-1:0]         rd_arch;
  logic [6*PW-1:0]         rd_phys;
  logic [ARCH_REGS*PW-1:0] map_after, recall_map;

  assign wmask    = lane_vld & lane_wr;
  assign need     = lane_count(wmask);
  assign in_ready = !br_bad && (avail >= HW'(need)) && !(grp_branch && snap_full);
  assign fire     = in_valid && in_ready;
  assign take     = fire ? wmask : '0;

  rename_freelist #(
    .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .PW(PW), .HW(HW)
  ) u_free (
    .clk(clk), .rst_n(rst_n),
    .take(take), .take_reg(new_reg),
    .avail(avail), .head_after(head_after),
    .give_en(cmt_free_en), .give_reg(cmt_free_reg),
    .rewind_en(br_bad), .rewind_head(recall_head)
  );

  rename_map #(
    .ARCH_REGS(ARCH_REGS), .AW(AW), .PW(PW)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_arch(rd_arch), .rd_phys(rd_phys),
    .wr_en(take), .wr_arch(lane_dst), .wr_phys(new_reg),
    .load_en(br_bad), .load_map(recall_map),
    .map_after(map_after)
  );

  rename_ckpt #(
    .NSNAP(SNAPS), .SW(SW), .ARCH_REGS(ARCH_REGS), .PW(PW), .HW(HW)
  ) u_ckpt (
    .clk(clk), .rst_n(rst_n),
    .save_en(fire && grp_branch), .save_map(map_after), .save_head(head_after),
    .save_id(out_snap_id), .full(snap_full),
    .release_en(br_ok),
    .recall_en(br_bad), .recall_id(br_bad_id),
    .recall_map(recall_map), .recall_head(recall_head)
  );

  // Per lane: read port 3l reads src a, 3l+1 reads src b, 3l+2 reads dst.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [AW-1:0] sa, sb, sd;
    logic [PW-1:0] ta, tb, td, nr;
    assign sa = lane_src_a[l*AW +: AW];
    assign sb = lane_src_b[l*AW +: AW];
    assign sd = lane_dst[l*AW +: AW];
    assign rd_arch[(3*l)*AW   +: AW] = sa;
    assign rd_arch[(3*l+1)*AW +: AW] = sb;
    assign rd_arch[(3*l+2)*AW +: AW] = sd;
    assign ta = rd_phys[(3*l)*PW   +: PW];
    assign tb = rd_phys[(3*l+1)*PW +: PW];
    assign td = rd_phys[(3*l+2)*PW +: PW];
    assign nr = new_reg[l*PW +: PW];

    if (l == 0) begin : g_first
      assign out_src_a[l*PW +: PW] = ta;
      assign out_src_b[l*PW +: PW] = tb;
      assign out_prev[l*PW +: PW]  = wmask[l] ? td : '0;
    end else begin : g_second
      // Same-group forwarding from the older lane.
      logic [AW-1:0] od;
      logic [PW-1:0] onr;
      logic          ow;
      assign od  = lane_dst[AW-1:0];
      assign onr = new_reg[PW-1:0];
      assign ow  = wmask[0];
      assign out_src_a[l*PW +: PW] = (ow && sa == od) ? onr : ta;
      assign out_src_b[l*PW +: PW] = (ow && sb == od) ? onr : tb;
      assign out_prev[l*PW +: PW]  = !wmask[l] ? '0 : ((ow && sd == od) ? onr : td);
    end
    assign out_dst[l*PW +: PW] = wmask[l] ? nr : '0;
  end
endmodule

// File: rtl/reg_rename_chk.sv
module reg_rename_chk #(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 48,
  parameter int SNAPS     = 4,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS),
  localparam int SW = $clog2(SNAPS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [1:0]      lane_vld,
  input logic [1:0]      lane_wr,
  input logic [2*AW-1:0] lane_src_a,
  input logic [2*AW-1:0] lane_dst,
  input logic            grp_branch,
  input logic [2*PW-1:0] out_src_a,
  input logic [2*PW-1:0] out_dst,
  input logic [2*PW-1:0] out_prev,
  input logic            br_ok,
  input logic            br_bad,
  input logic [SW-1:0]   br_bad_id
);
  logic          fire;
  logic [SW:0]   outstanding;
  logic [SW-1:0] oldest;
  assign fire = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= '0;
      oldest      <= '0;
    end else begin
      if (br_bad) outstanding <= {1'b0, br_bad_id - oldest};
      else outstanding <= outstanding + (SW+1)'(fire && grp_branch) - (SW+1)'(br_ok);
      if (br_ok) oldest <= oldest + SW'(1);
    end
  end

  assert_distinct_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (&(lane_vld & lane_wr))) |-> (out_dst[PW-1:0] != out_dst[2*PW-1:PW]));

  assert_prev_matches_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && lane_vld[0] && lane_wr[0] && lane_src_a[AW-1:0] == lane_dst[AW-1:0])
      |-> (out_prev[PW-1:0] == out_src_a[PW-1:0]));

  assert_newest_mapping_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && lane_vld[0] && !br_bad && !$past(br_bad)
      && $past(fire && lane_vld[1] && lane_wr[1])
      && lane_src_a[AW-1:0] == $past(lane_dst[2*AW-1:AW]))
      |-> (out_src_a[PW-1:0] == $past(out_dst[2*PW-1:PW])));

  assert_ckpt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && grp_branch) |-> (outstanding < (SW+1)'(SNAPS)));
endmodule

bind reg_rename reg_rename_chk #(
  .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .SNAPS(SNAPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .lane_vld(lane_vld), .lane_wr(lane_wr), .lane_src_a(lane_src_a),
  .lane_dst(lane_dst), .grp_branch(grp_branch), .out_src_a(out_src_a),
  .out_dst(out_dst), .out_prev(out_prev), .br_ok(br_ok), .br_bad(br_bad),
  .br_bad_id(br_bad_id)
);

// File: tb/reg_rename_bench.sv
module reg_rename_bench;
  localparam int NA = 4, NP = 8, NS = 2;
  localparam int AW = 2, PW = 3, SW = 1;

  logic clk, rst_n;
  logic in_valid, in_ready, grp_branch;
  logic [1:0] lane_vld, lane_wr;
  logic [2*AW-1:0] lane_src_a, lane_src_b, lane_dst;
  logic [2*PW-1:0] out_src_a, out_src_b, out_dst, out_prev;
  logic [SW-1:0] out_snap_id, br_bad_id;
  logic cmt_free_en, br_ok, br_bad;
  logic [PW-1:0] cmt_free_reg;

  reg_rename #(.ARCH_REGS(NA), .PHYS_REGS(NP), .SNAPS(NS)) u_reg_rename (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .lane_vld(lane_vld), .lane_wr(lane_wr), .lane_src_a(lane_src_a),
    .lane_src_b(lane_src_b), .lane_dst(lane_dst), .grp_branch(grp_branch),
    .out_src_a(out_src_a), .out_src_b(out_src_b), .out_dst(out_dst),
    .out_prev(out_prev), .out_snap_id(out_snap_id), .cmt_free_en(cmt_free_en),
    .cmt_free_reg(cmt_free_reg), .br_ok(br_ok), .br_bad(br_bad), .br_bad_id(br_bad_id)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int ntot = 0, nfail = 0, cyc = 0;

  // Reference state
  int mmap [NA];
  int fq [4096];
  int fh, ft;
  int smap [NS][NA];
  int shead [NS];
  int spb [NS];
  int s_old, s_new;
  int pq [4096];
  int pf, pb;

  task automatic finish_run();
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      ntot++; nfail++;
      $display("FAIL watchdog (all) actual=%0d cycles expected<=100000", cyc);
      finish_run();
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    ntot++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string pick(string tag, string dflt);
    return (tag == "") ? dflt : tag;
  endfunction

  // One group, offered for one cycle; checks outputs against the reference.
  task automatic grp(bit v0, bit w0, int a0, int b0, int d0,
                     bit v1, bit w1, int a1, int b1, int d1,
                     bit br, string tag);
    int tm [NA];
    int f, need;
    bit rdy;
    int ea0, eb0, ed0, ep0, ea1, eb1, ed1, ep1;
    @(negedge clk);
    in_valid   = 1'b1;
    grp_branch = br;
    lane_vld   = {v1, v0};
    lane_wr    = {w1, w0};
    lane_src_a = {AW'(a1), AW'(a0)};
    lane_src_b = {AW'(b1), AW'(b0)};
    lane_dst   = {AW'(d1), AW'(d0)};
    need = int'(v0 && w0) + int'(v1 && w1);
    rdy  = (need <= ft - fh) && (!br || (s_new - s_old) < NS);
    #5;
    chk(pick(tag, br ? "R10" : "R7"), int'(in_ready), int'(rdy), "in_ready");
    for (int i = 0; i < NA; i++) tm[i] = mmap[i];
    f = fh;
    ep0 = -1; ep1 = -1;
    if (rdy) begin
      // Sequential semantics: lane 0 first, then lane 1 sees its effect.
      if (v0) begin
        ea0 = tm[a0]; eb0 = tm[b0];
        chk(pick(tag, "R2"), int'(out_src_a[PW-1:0]), ea0, "lane0 src_a");
        chk(pick(tag, "R2"), int'(out_src_b[PW-1:0]), eb0, "lane0 src_b");
        if (w0) begin
          ep0 = tm[d0]; ed0 = fq[f]; f++; tm[d0] = ed0;
          chk(pick(tag, "R3"), int'(out_dst[PW-1:0]), ed0, "lane0 dst");
          chk(pick(tag, "R4"), int'(out_prev[PW-1:0]), ep0, "lane0 prev");
        end
      end
      if (v1) begin
        ea1 = tm[a1]; eb1 = tm[b1];
        chk(pick(tag, (v0 && w0 && a1 == d0) ? "R5" : "R2"),
            int'(out_src_a[2*PW-1:PW]), ea1, "lane1 src_a");
        chk(pick(tag, (v0 && w0 && b1 == d0) ? "R5" : "R2"),
            int'(out_src_b[2*PW-1:PW]), eb1, "lane1 src_b");
        if (w1) begin
          ep1 = tm[d1]; ed1 = fq[f]; f++; tm[d1] = ed1;
          chk(pick(tag, "R3"), int'(out_dst[2*PW-1:PW]), ed1, "lane1 dst");
          chk(pick(tag, (v0 && w0 && d1 == d0) ? "R6" : "R4"),
              int'(out_prev[2*PW-1:PW]), ep1, "lane1 prev");
        end
      end
      if (br) chk(pick(tag, "R9"), int'(out_snap_id), s_new % NS, "snap id");
    end
    @(posedge clk); #1;
    if (rdy) begin
      for (int i = 0; i < NA; i++) mmap[i] = tm[i];
      fh = f;
      if (ep0 >= 0) begin pq[pb] = ep0; pb++; end
      if (ep1 >= 0) begin pq[pb] = ep1; pb++; end
      if (br) begin
        for (int i = 0; i < NA; i++) smap[s_new % NS][i] = tm[i];
        shead[s_new % NS] = fh;
        spb[s_new % NS]   = pb;
        s_new++;
      end
    end
    in_valid = 1'b0; grp_branch = 1'b0; lane_vld = '0; lane_wr = '0;
  endtask

  // Read every architectural register through a non-writing group.
  task automatic read_all(string tag);
    grp(1'b1, 1'b0, 0, 1, 0, 1'b1, 1'b0, 2, 3, 0, 1'b0, tag);
  endtask

  task automatic free_n(int n);
    for (int k = 0; k < n; k++) begin
      if (pf < pb) begin
        @(negedge clk);
        cmt_free_en = 1'b1; cmt_free_reg = PW'(pq[pf]);
        @(posedge clk); #1;
        fq[ft] = pq[pf]; ft++; pf++;
        cmt_free_en = 1'b0;
      end
    end
  endtask

  task automatic resolve_ok();
    @(negedge clk); br_ok = 1'b1;
    @(posedge clk); #1;
    s_old++; br_ok = 1'b0;
  endtask

  task automatic mispredict(int id);
    @(negedge clk);
    br_bad = 1'b1; br_bad_id = SW'(id);
    in_valid = 1'b1; lane_vld = '0; lane_wr = '0;  // group needs nothing
    #5;
    chk("R9", int'(in_ready), 0, "in_ready during restore");
    @(posedge clk); #1;
    for (int i = 0; i < NA; i++) mmap[i] = smap[id][i];
    fh = shead[id];
    pb = spb[id];
    s_new = s_old + ((id - (s_old % NS) + NS) % NS);
    br_bad = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    int id0, r;
    rst_n = 1'b0; in_valid = 1'b0; grp_branch = 1'b0;
    lane_vld = '0; lane_wr = '0; lane_src_a = '0; lane_src_b = '0; lane_dst = '0;
    cmt_free_en = 1'b0; cmt_free_reg = '0; br_ok = 1'b0; br_bad = 1'b0; br_bad_id = '0;
    for (int i = 0; i < NA; i++) mmap[i] = i;
    for (int j = 0; j < NP - NA; j++) fq[j] = NA + j;
    fh = 0; ft = NP - NA; s_old = 0; s_new = 0; pf = 0; pb = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #5;
    chk("R1", int'(in_ready), 1, "in_ready after reset");

    // R1: identity map and first allocations in ascending order
    read_all("R1");
    grp(1'b1, 1'b1, 0, 1, 1, 1'b1, 1'b1, 1, 2, 2, 1'b0, "");  // lane1 src_a forwarded (R5)
    free_n(2);
    // R6: both lanes write the same register
    grp(1'b1, 1'b1, 3, 3, 3, 1'b1, 1'b1, 3, 0, 3, 1'b0, "");
    read_all("R6");
    // R7: drain the free list, then a writing group must stall
    grp(1'b1, 1'b1, 0, 1, 0, 1'b1, 1'b1, 0, 1, 1, 1'b0, "");
    grp(1'b1, 1'b1, 2, 3, 2, 1'b0, 1'b0, 0, 0, 0, 1'b0, "R7");
    read_all("R7");
    // R8: a returned register is handed out behind the ones already free
    free_n(3);
    grp(1'b1, 1'b1, 0, 0, 2, 1'b0, 1'b0, 0, 0, 0, 1'b0, "R8");
    grp(1'b1, 1'b1, 1, 1, 3, 1'b1, 1'b1, 3, 2, 0, 1'b0, "R8");
    // R9: checkpoint, wrong path, restore
    free_n(4);
    id0 = s_new % NS;
    grp(1'b1, 1'b1, 1, 2, 2, 1'b0, 1'b0, 0, 0, 0, 1'b1, "R9");
    grp(1'b1, 1'b1, 2, 0, 0, 1'b1, 1'b1, 0, 2, 1, 1'b0, "");
    mispredict(id0);
    read_all("R9");
    grp(1'b1, 1'b1, 2, 3, 3, 1'b0, 1'b0, 0, 0, 0, 1'b0, "R9");
    // R10: fill both slots, third branch stalls, plain group passes
    grp(1'b1, 1'b0, 0, 1, 0, 1'b0, 1'b0, 0, 0, 0, 1'b1, "R10");
    grp(1'b1, 1'b0, 2, 3, 0, 1'b0, 1'b0, 0, 0, 0, 1'b1, "R10");
    grp(1'b1, 1'b0, 1, 2, 0, 1'b0, 1'b0, 0, 0, 0, 1'b1, "R10");
    grp(1'b1, 1'b0, 3, 0, 0, 1'b0, 1'b0, 0, 0, 0, 1'b0, "R10");
    resolve_ok();
    grp(1'b1, 1'b0, 1, 2, 0, 1'b0, 1'b0, 0, 0, 0, 1'b1, "R10");
    resolve_ok();
    resolve_ok();
    // Mixed traffic wraps the free-list pointers
    for (int it = 0; it < 80; it++) begin
      r = int'($urandom % 4);
      if (r == 3) free_n(1);
      else grp(1'b1, 1'($urandom % 2), int'($urandom % NA), int'($urandom % NA),
               int'($urandom % NA), 1'b1, 1'($urandom % 2), int'($urandom % NA),
               int'($urandom % NA), int'($urandom % NA), 1'b0, "");
    end
    read_all("R2");
    finish_run();
  end
endmodule